// File: doc/BRIEF.md
# Kick Watchdog with Reset Coupling

This block supervises a host by watching a kick input. Every rising or falling edge on the kick line, once it has been brought into the clock domain, restarts a timeout counter. If the counter runs out, the block signals the lapse on an active-low watchdog output. Optionally, the lapse can also be routed into the active-low system reset output as a reset pulse of fixed length. Time is counted in ticks, and each tick is a fixed number of clock cycles set by a parameter. All timeout values are given in ticks.

The first period after the watchdog starts uses a separate startup timeout. This gives the host time to boot. Every later period uses the normal timeout. The watchdog can be made to depend on the power sequencer: it then sleeps until the sequencer reports completion. In independent mode it runs whatever the sequencer state. When reset coupling is on, the reset pulse clears the timer, so the watchdog output shows only a single-tick low pulse before the reset begins.

Top module: `kick_watchdog`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `wdo_n` and `reset_n` are both high.
- R2: With `indep_mode` = 0 and `seq_done` = 0, the watchdog is idle: both outputs stay high whatever `wdi` does.
- R3: With `indep_mode` = 1, the watchdog runs even when `seq_done` = 0.
- R4: When the watchdog starts from idle, it loads `startup_ticks`, so the first lapse comes `startup_ticks` ticks after the start.
- R5: Each edge on `wdi`, rising or falling, is seen after a two-flop synchronizer and reloads the counter with `normal_ticks`. A kick wins over a tick in the same cycle.
- R6: With `rst_couple_en` = 0, a lapse drives `wdo_n` low. It stays low until the next `wdi` edge, and `reset_n` stays high.
- R7: With `rst_couple_en` = 1, a lapse drives `wdo_n` low for exactly one tick. At the end of that tick `wdo_n` returns high and `reset_n` goes low for `pulse_ticks` ticks. The two outputs are never low together.
- R8: Edges on `wdi` during the low pulse on `wdo_n` and during the reset pulse are ignored: the reset length does not change.
- R9: When the reset pulse ends, the counter restarts with `normal_ticks`. The next lapse without kicks comes exactly `normal_ticks` ticks after `reset_n` rises.
- R10: Leaving the active condition releases both outputs in the next cycle. A later restart uses `startup_ticks` again.
- R11: A tick occurs once every PRESCALE clock cycles. Counts change only on ticks. A timeout value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdi | input | 1 | Kick input, asynchronous, either edge counts |
| rst_couple_en | input | 1 | 1 = a lapse produces a reset pulse |
| indep_mode | input | 1 | 1 = run regardless of the sequencer |
| seq_done | input | 1 | Sequencer has finished power-up |
| startup_ticks | input | CNT_W | Timeout of the first period, in ticks |
| normal_ticks | input | CNT_W | Timeout of later periods, in ticks |
| pulse_ticks | input | RST_W | Reset pulse length, in ticks |
| wdo_n | output | 1 | Watchdog lapse, active low |
| reset_n | output | 1 | System reset, active low |

## Verification
On every cycle, the assertions check several properties. The two outputs are never low together. The reset falls exactly as the watchdog output rises. Both outputs are released once the block is inactive. The reset changes only on a tick, and ticks are spaced apart. A held lapse clears only through a kick. The exact lengths cannot be seen by a single-cycle property, and the bench's scenarios are what show them: the startup window, the one-tick pulse, the reset length, the normal-period restart after a reset, kicks ignored during reset, and a zero timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_RUN   = 3'd1,
    WS_HOLD  = 3'd2,
    WS_PULSE = 3'd3,
    WS_RST   = 3'd4
  } wdg_state_e;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int PRESCALE = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk) begin
        if (rst)               pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                   pcnt <= pcnt + 1'b1;
      end

      assign tick = (pcnt == LAST);

      // R11
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_pulse
);
  localparam int SW = SYNC_STAGES + 1;
  logic [SW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SW-2:0], din};
  end

  assign edge_pulse = sh[SW-1] ^ sh[SW-2];
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RST_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic             indep_mode,
  input  logic             seq_done,
  input  logic             couple_en,
  input  logic [CNT_W-1:0] start_to,
  input  logic [CNT_W-1:0] norm_to,
  input  logic [RST_W-1:0] rst_len,
  output logic             wdo_n,
  output logic             reset_n
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [RST_W-1:0] RST_ONE = RST_W'(1);

  wdg_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [RST_W-1:0] rcnt;
  logic             active;

  assign active = indep_mode | seq_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= WS_IDLE;
      cnt     <= '0;
      rcnt    <= '0;
      wdo_n   <= 1'b1;
      reset_n <= 1'b1;
    end else if (!active) begin
      st      <= WS_IDLE;
      wdo_n   <= 1'b1;
      reset_n <= 1'b1;
    end else begin
      unique case (st)
        WS_IDLE: begin
          st  <= WS_RUN;
          cnt <= start_to;
        end
        WS_RUN: begin
          if (kick) begin
            cnt <= norm_to;
          end else if (tick) begin
            if (cnt <= CNT_ONE) begin
              wdo_n <= 1'b0;
              st    <= couple_en ? WS_PULSE : WS_HOLD;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        WS_HOLD: begin
          if (kick) begin
            st    <= WS_RUN;
            cnt   <= norm_to;
            wdo_n <= 1'b1;
          end
        end
        WS_PULSE: begin
          if (tick) begin
            st      <= WS_RST;
            wdo_n   <= 1'b1;
            reset_n <= 1'b0;
            rcnt    <= rst_len;
          end
        end
        WS_RST: begin
          if (tick) begin
            if (rcnt <= RST_ONE) begin
              st      <= WS_RUN;
              reset_n <= 1'b1;
              cnt     <= norm_to;
            end else begin
              rcnt <= rcnt - 1'b1;
            end
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  // R7
  no_both_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(!wdo_n && !reset_n));

  // R7
  rst_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_n) |-> $rose(wdo_n));

  // R10
  inactive_release_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (wdo_n && reset_n));

  // R11
  reset_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(reset_n) && $past(active)) |-> $past(tick));

  // R6
  hold_until_kick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == WS_HOLD && $past(active) && !$past(kick)) |-> !wdo_n);
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
  parameter int PRESCALE    = 100,
  parameter int CNT_W       = 16,
  parameter int RST_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdi,
  input  logic             rst_couple_en,
  input  logic             indep_mode,
  input  logic             seq_done,
  input  logic [CNT_W-1:0] startup_ticks,
  input  logic [CNT_W-1:0] normal_ticks,
  input  logic [RST_W-1:0] pulse_ticks,
  output logic             wdo_n,
  output logic             reset_n
);
  logic tick;
  logic kick;

  wdg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  wdg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .din        (wdi),
    .edge_pulse (kick)
  );

  wdg_core #(.CNT_W(CNT_W), .RST_W(RST_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .kick       (kick),
    .indep_mode (indep_mode),
    .seq_done   (seq_done),
    .couple_en  (rst_couple_en),
    .start_to   (startup_ticks),
    .norm_to    (normal_ticks),
    .rst_len    (pulse_ticks),
    .wdo_n      (wdo_n),
    .reset_n    (reset_n)
  );
endmodule

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;
  localparam int PERIOD = 10;
  localparam int P      = 4;
  localparam int CW     = 8;
  localparam int RW     = 8;
  localparam int S_T    = 20;
  localparam int N_T    = 6;
  localparam int L_T    = 5;

  logic clk = 1'b0;
  logic rst, wdi, couple, indep, seq;
  logic [CW-1:0] st_t, nm_t;
  logic [RW-1:0] pl_t;
  logic wdo_n, reset_n;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  kick_watchdog #(.PRESCALE(P), .CNT_W(CW), .RST_W(RW), .SYNC_STAGES(2)) u_kick_watchdog (
    .clk(clk), .rst(rst), .wdi(wdi), .rst_couple_en(couple),
    .indep_mode(indep), .seq_done(seq),
    .startup_ticks(st_t), .normal_ticks(nm_t), .pulse_ticks(pl_t),
    .wdo_n(wdo_n), .reset_n(reset_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int  pc, mst, mcnt, mrc;
  bit  mw = 1'b1, mr = 1'b1;
  bit  wq[$];
  bit  mk, mt;

  always @(posedge clk) begin
    if (rst) begin
      pc = 0; mst = 0; mcnt = 0; mrc = 0; mw = 1; mr = 1;
      wq = '{0, 0, 0};
    end else begin
      mk = (wq[1] != wq[2]);
      mt = (pc == P - 1);
      pc = (pc + 1) % P;
      wq.push_front(wdi);
      void'(wq.pop_back());
      if (!(indep || seq)) begin
        mst = 0; mw = 1; mr = 1;
      end else begin
        case (mst)
          0: begin mst = 1; mcnt = int'(st_t); end
          1: if (mk) mcnt = int'(nm_t);
             else if (mt) begin
               if (mcnt <= 1) begin mw = 0; mst = couple ? 3 : 2; end
               else mcnt--;
             end
          2: if (mk) begin mst = 1; mcnt = int'(nm_t); mw = 1; end
          3: if (mt) begin mst = 4; mw = 1; mr = 0; mrc = int'(pl_t); end
          4: if (mt) begin
               if (mrc <= 1) begin mst = 1; mr = 1; mcnt = int'(nm_t); end
               else mrc--;
             end
          default: mst = 0;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #1;
    // per-cycle comparison covers R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    chk(wdo_n == mw, "R6 R7", "per-cycle wdo_n", int'(wdo_n), int'(mw));
    chk(reset_n == mr, "R7 R9", "per-cycle reset_n", int'(reset_n), int'(mr));
  end

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired: actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, w, r, m;
    bit stayed;
    rst = 1; wdi = 0; couple = 0; indep = 0; seq = 0;
    st_t = CW'(S_T); nm_t = CW'(N_T); pl_t = RW'(L_T);
    repeat (4) @(negedge clk);
    chk(wdo_n && reset_n, "R1", "outputs during reset", int'({wdo_n, reset_n}), 3);
    rst = 0;
    @(negedge clk);
    chk(wdo_n && reset_n, "R1", "outputs after reset", int'({wdo_n, reset_n}), 3);

    // R2: idle while sequencer not done
    for (int i = 0; i < 10; i++) begin
      wdi = ~wdi;
      repeat (7) @(negedge clk);
    end
    repeat (100) @(negedge clk);
    chk(wdo_n && reset_n, "R2", "idle outputs", int'({wdo_n, reset_n}), 3);

    // R4: startup period
    seq = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (wdo_n && n < 500);
    chk(n >= (S_T - 1) * P + 1 && n <= S_T * P + 2, "R4", "startup lapse cycles", n, S_T * P);

    // R6: held lapse
    repeat (60) @(negedge clk);
    chk(!wdo_n && reset_n, "R6", "lapse held", int'({wdo_n, reset_n}), 1);
    wdi = ~wdi;
    repeat (5) @(negedge clk);
    chk(wdo_n == 1'b1, "R6", "kick releases wdo_n", int'(wdo_n), 1);

    // R5: periodic kicks keep it quiet
    stayed = 1;
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < (N_T - 2) * P; c++) begin
        @(negedge clk);
        if (!wdo_n) stayed = 0;
      end
      wdi = ~wdi;
    end
    chk(stayed, "R5", "no lapse with kicks", int'(stayed), 1);

    // R7 / R8 / R9: coupled reset
    couple = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (wdo_n && n < 500);
    w = 1;
    forever begin @(negedge clk); if (!wdo_n) w++; else break; end
    chk(w == P, "R7", "wdo_n pulse cycles", w, P);
    chk(reset_n == 1'b0, "R7", "reset follows pulse", int'(reset_n), 0);
    r = 1;
    forever begin
      @(negedge clk);
      if (r == 3) wdi = ~wdi;
      if (!reset_n) r++; else break;
    end
    chk(r == L_T * P, "R8", "reset cycles with kick inside", r, L_T * P);
    m = 0;
    do begin @(negedge clk); m++; end while (wdo_n && m < 500);
    chk(m == N_T * P, "R9", "normal period after reset", m, N_T * P);

    // R10: deactivate during reset
    n = 0;
    do begin @(negedge clk); n++; end while (reset_n && n < 100);
    seq = 0;
    @(negedge clk);
    chk(wdo_n && reset_n, "R10", "release on inactive", int'({wdo_n, reset_n}), 3);

    // R3: independent mode restarts with startup period
    indep = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (wdo_n && n < 500);
    chk(n >= (S_T - 1) * P + 1 && n <= S_T * P + 2, "R3", "independent startup lapse", n, S_T * P);

    // R11: zero timeout behaves as one tick
    couple = 0;
    nm_t = '0;
    n = 0;
    do begin @(negedge clk); n++; end while (!reset_n && n < 100);
    do begin @(negedge clk); n++; end while (reset_n && n < 100);
    do begin @(negedge clk); n++; end while (!reset_n && n < 100);
    m = 0;
    do begin @(negedge clk); m++; end while (wdo_n && m < 100);
    chk(m == P, "R11", "zero timeout lapse cycles", m, P);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule